// File: doc/BRIEF.md
# Debug breakpoint trigger comparator

This block watches the accesses a processor makes on its local bus and raises a breakpoint trigger when an access meets the conditions software has set. Each access carries an address, a 32-bit data value, a size, and the program counter of the instruction that made it. All of these arrive together in the cycle where the access-valid input is high. Three comparator groups are available. The address group matches one address exactly, or an inclusive window, or anything outside that window. The data group compares the bus value with a data register on a chosen byte, word or longword lane. The PC group compares the program counter against a base value through a bit mask, and it can match inside or outside the masked region.

Software programs the six configuration registers through a one-cycle write port. The control register holds the enable and mode bits for every group. A group whose enables are all clear takes no part in the decision. When several groups are enabled, all of them must match on the same access. The result is a registered pulse, `trig`, in the cycle after the access.

Top module: `bkpt_match`

Register select codes on `cfg_sel`:
- 0: control
- 1: low address
- 2: high address
- 3: data
- 4: PC base
- 5: PC mask

Control bits:
- bit 0: PC enable
- bit 1: PC invert
- bit 2: exact address
- bit 3: inside range
- bit 4: outside range
- bit 5: data invert
- bit 6: longword lane
- bit 7: lower word (15:0)
- bit 8: upper word (31:16)
- bit 9: byte 7:0
- bit 10: byte 15:8
- bit 11: byte 23:16
- bit 12: byte 31:24

Access size codes on `acc_size`:
- 0: byte
- 1: word
- 2: longword
- 3: reserved; it occupies no lane.

## Requirements
- R1: After reset all enables are clear. `trig` is 0, and no access produces a trigger until the control register is written.
- R2: `trig` is high in the cycle after a cycle with `acc_valid`=1 in which every enabled group matches. It is low after a cycle with `acc_valid`=0, whatever the other inputs are.
- R3: With control bit 2 set, the address group matches only when `acc_addr` equals the low address register.
- R4: With control bit 3 set, the address group matches when low <= `acc_addr` <= high. Both bounds are included.
- R5: With control bit 4 set, the address group matches only when `acc_addr` is below low or above high. If more than one address bit is set, bit 2 takes precedence over bit 3, and bit 3 over bit 4.
- R6: A data lane enable counts only when the access exactly occupies that lane:
  - the longword lane needs size 2;
  - a word access with `acc_addr[1]`=0 uses bits 31:16, and with `acc_addr[1]`=1 it uses bits 15:0;
  - a byte access at `acc_addr[1:0]` = 0, 1, 2 or 3 uses bits 31:24, 23:16, 15:8 or 7:0 respectively.
- R7: On an occupied and enabled lane, the data group matches when the bus bits on that lane equal the same bits of the data register. Bits outside the lane are ignored.
- R8: Control bit 5 inverts every data lane comparison, so an occupied lane matches when its bits differ. Lane occupancy is still required.
- R9: With control bit 0 set, the PC group matches when (`acc_pc` XOR base) AND mask is zero. A mask bit of 1 makes that bit take part in the comparison. Control bit 1 inverts this result.
- R10: When several groups are enabled, all of them must match on the same access.
- R11: A register write takes effect from the next cycle. An access in the same cycle as the write is judged by the old value, and clearing the control register disables every trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | AW | Access address |
| acc_data | input | 32 | Access data |
| acc_size | input | 2 | Access size code |
| acc_pc | input | AW | PC of the instruction making the access |
| trig | output | 1 | Registered breakpoint trigger pulse |

## Verification
The hardest cases to reach are the ones where a lane compare succeeds but the lane is not occupied. One example is a word-sized access whose data matches the data register while only the longword lane is enabled. Another is a byte access at the wrong offset that carries the right byte. The stimulus builds these by keeping the bus data fixed and changing only the size or the low address bits, so that the expected trigger turns off for occupancy alone. A register write in the same cycle as a matching access checks that the old configuration is still in use.

// File: rtl/bkpt_match.sv
module bkpt_match #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [31:0]   cfg_wdata,
  input  logic          acc_valid,
  input  logic [AW-1:0] acc_addr,
  input  logic [31:0]   acc_data,
  input  logic [1:0]    acc_size,
  input  logic [AW-1:0] acc_pc,
  output logic          trig
);
  localparam int CW = 13;

  logic [CW-1:0] ctrl_q;
  logic [AW-1:0] lo_q, hi_q, pcb_q, pcm_q;
  logic [31:0]   dat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      dat_q  <= '0;
      pcb_q  <= '0;
      pcm_q  <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        3'd0: ctrl_q <= cfg_wdata[CW-1:0];
        3'd1: lo_q   <= cfg_wdata[AW-1:0];
        3'd2: hi_q   <= cfg_wdata[AW-1:0];
        3'd3: dat_q  <= cfg_wdata;
        3'd4: pcb_q  <= cfg_wdata[AW-1:0];
        3'd5: pcm_q  <= cfg_wdata[AW-1:0];
        default: ;
      endcase
    end
  end

  wire pc_en   = ctrl_q[0];
  wire pc_inv  = ctrl_q[1];
  wire addr_en = |ctrl_q[4:2];
  wire d_inv   = ctrl_q[5];
  wire [6:0] d_en = ctrl_q[12:6];
  wire data_en = |d_en;

  wire in_rng   = (acc_addr >= lo_q) && (acc_addr <= hi_q);
  wire addr_hit = ctrl_q[2] ? (acc_addr == lo_q) : ctrl_q[3] ? in_rng : !in_rng;

  wire is_b = acc_size == 2'd0;
  wire is_w = acc_size == 2'd1;
  wire is_l = acc_size == 2'd2;
  wire [1:0] ofs = acc_addr[1:0];

  wire [6:0] occ = {is_b && ofs == 2'd0, is_b && ofs == 2'd1,
                    is_b && ofs == 2'd2, is_b && ofs == 2'd3,
                    is_w && !ofs[1], is_w && ofs[1], is_l};
  wire [6:0] eq  = {acc_data[31:24] == dat_q[31:24], acc_data[23:16] == dat_q[23:16],
                    acc_data[15:8]  == dat_q[15:8],  acc_data[7:0]   == dat_q[7:0],
                    acc_data[31:16] == dat_q[31:16], acc_data[15:0]  == dat_q[15:0],
                    acc_data == dat_q};
  wire data_hit = |(d_en & occ & (eq ^ {7{d_inv}}));

  wire pc_in  = ((acc_pc ^ pcb_q) & pcm_q) == '0;
  wire pc_hit = pc_in ^ pc_inv;

  wire fire = acc_valid && (addr_en || data_en || pc_en) &&
              (!addr_en || addr_hit) && (!data_en || data_hit) && (!pc_en || pc_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) trig <= 1'b0;
    else        trig <= fire;
  end

  // R2
  trig_needs_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> $past(acc_valid));

  // R1
  no_enable_no_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctrl_q) == '0) |-> !trig);

  // R3
  exact_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && $past(ctrl_q[2])) |-> $past(acc_addr == lo_q));

  // R9
  pc_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && $past(pc_en && !pc_inv)) |-> $past(((acc_pc ^ pcb_q) & pcm_q) == '0));

  // R6
  long_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && $past(d_en == 7'b0000001)) |-> $past(acc_size == 2'd2));

  // R4
  range_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && $past(ctrl_q[4:2] == 3'b010)) |-> $past(acc_addr >= lo_q && acc_addr <= hi_q));
endmodule

// File: tb/bkpt_match_tb_top.sv
`timescale 1ns/1ps
module bkpt_match_tb_top;
  localparam int AW = 32;
  localparam int PC_EN = 1 << 0, PC_INV = 1 << 1, A_EQ = 1 << 2, A_IN = 1 << 3,
                 A_OUT = 1 << 4, D_INV = 1 << 5, D_L = 1 << 6, D_LW = 1 << 7,
                 D_UW = 1 << 8, D_LL = 1 << 9, D_UU = 1 << 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic acc_valid = 1'b0;
  logic [AW-1:0] acc_addr = '0, acc_pc = '0;
  logic [31:0] acc_data = '0;
  logic [1:0] acc_size = '0;
  logic trig;

  int checks = 0, fails = 0;
  bit    exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  bkpt_match #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_data(acc_data), .acc_size(acc_size), .acc_pc(acc_pc), .trig(trig));

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      bit e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (trig !== e) begin
        fails++;
        $display("FAIL %s: trig=%0b expected %0b", t, trig, e);
      end
    end
  end

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    acc_valid = 1'b0;
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic acc(input logic v, input logic [31:0] a, input logic [31:0] d,
                     input logic [1:0] sz, input logic [31:0] pc, input bit e, input string t);
    @(negedge clk);
    acc_valid = v; acc_addr = a; acc_data = d; acc_size = sz; acc_pc = pc;
    @(posedge clk);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog: expired expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (trig !== 1'b0) begin fails++; $display("FAIL R1: trig=%0b expected 0", trig); end
    acc(1, 32'h0, 32'h0, 2, 32'h0, 0, "R1 reset no trigger");

    wr(1, 32'h1000); wr(2, 32'h10FF); wr(0, A_EQ);
    acc(1, 32'h1000, 0, 2, 0, 1, "R3 exact hit");
    acc(1, 32'h1004, 0, 2, 0, 0, "R3 exact miss");
    acc(0, 32'h1000, 0, 2, 0, 0, "R2 no valid");

    wr(0, A_IN);
    acc(1, 32'h1000, 0, 2, 0, 1, "R4 low bound");
    acc(1, 32'h10FF, 0, 2, 0, 1, "R4 high bound");
    acc(1, 32'h1100, 0, 2, 0, 0, "R4 above");
    acc(1, 32'h0FFF, 0, 2, 0, 0, "R4 below");

    wr(0, A_OUT);
    acc(1, 32'h0FFF, 0, 2, 0, 1, "R5 below");
    acc(1, 32'h1100, 0, 2, 0, 1, "R5 above");
    acc(1, 32'h1080, 0, 2, 0, 0, "R5 inside");
    wr(0, A_EQ | A_OUT);
    acc(1, 32'h1000, 0, 2, 0, 1, "R5 exact precedence");

    wr(3, 32'hA1B2C3D4); wr(0, D_L);
    acc(1, 0, 32'hA1B2C3D4, 2, 0, 1, "R7 long match");
    acc(1, 0, 32'hA1B2C3D5, 2, 0, 0, "R7 long mismatch");
    acc(1, 0, 32'hA1B2C3D4, 1, 0, 0, "R6 long lane needs long size");

    wr(0, D_UU);
    acc(1, 0, 32'hA1000000, 0, 0, 1, "R6 byte 31:24 at offset 0");
    acc(1, 3, 32'hA1000000, 0, 0, 0, "R6 byte wrong offset");
    wr(0, D_LL);
    acc(1, 3, 32'h555555D4, 0, 0, 1, "R7 byte 7:0 others ignored");

    wr(0, D_UW);
    acc(1, 0, 32'hA1B20000, 1, 0, 1, "R6 upper word");
    wr(0, D_LW);
    acc(1, 2, 32'h0000C3D4, 1, 0, 1, "R6 lower word");
    acc(1, 0, 32'h0000C3D4, 1, 0, 0, "R6 lower word wrong offset");

    wr(0, D_L | D_INV);
    acc(1, 0, 32'h0, 2, 0, 1, "R8 invert differs");
    acc(1, 0, 32'hA1B2C3D4, 2, 0, 0, "R8 invert equal");
    acc(1, 0, 32'h0, 1, 0, 0, "R8 invert needs occupancy");

    wr(4, 32'h2000); wr(5, 32'hFFFFF000); wr(0, PC_EN);
    acc(1, 0, 0, 2, 32'h2ABC, 1, "R9 pc inside");
    acc(1, 0, 0, 2, 32'h3000, 0, "R9 pc outside");
    wr(0, PC_EN | PC_INV);
    acc(1, 0, 0, 2, 32'h3000, 1, "R9 inverted outside");
    acc(1, 0, 0, 2, 32'h2ABC, 0, "R9 inverted inside");

    wr(0, A_EQ | PC_EN);
    acc(1, 32'h1000, 0, 2, 32'h2004, 1, "R10 both match");
    acc(1, 32'h1000, 0, 2, 32'h4004, 0, "R10 pc misses");
    acc(1, 32'h1001, 0, 2, 32'h2004, 0, "R10 addr misses");

    wr(0, A_EQ);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 0; cfg_wdata = 0;
    acc_valid = 1'b1; acc_addr = 32'h1000; acc_size = 2;
    @(posedge clk);
    exp_q.push_back(1'b1); tag_q.push_back("R11 same-cycle write uses old");
    @(negedge clk);
    cfg_we = 1'b0;
    @(posedge clk);
    exp_q.push_back(1'b0); tag_q.push_back("R11 cleared control disables");

    @(negedge clk);
    acc_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    summary();
  end
endmodule